// File: doc/BRIEF.md
# Checkpoint Coordinator

A central controller that runs a two-phase handshake for taking a global checkpoint. On request it raises one broadcast line that tells every participant to save its state: a group of node controllers (cores and cache save engines) and a group of memory-log flushers. Each participant answers with its own done line. The coordinator records each answer in a sticky bit, so an answer counts even if the line drops again. When every participant has answered, the coordinator lowers the broadcast line. That falling edge is the commit: on it each participant switches its active checkpoint copy, or marks a boundary in its log.

A request that arrives while a checkpoint is under way is never lost. It is held pending and started as soon as the commit has settled. A sequence counter steps once per commit. An optional watchdog raises an error flag when the answers take longer than a programmable number of cycles. The coordinator keeps waiting in that case, and the flag does not abort the checkpoint.

Top module: `ckpt_coordinator`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ckpt_o`, `busy_o`, `epoch_o` and `wdog_err_o` are all 0. A reset taken in the middle of a checkpoint also returns them to 0.
- R2: A high `ckpt_req_i` sampled while `busy_o` is 0 makes `ckpt_o` and `busy_o` go to 1 after that clock edge.
- R3: While `ckpt_o` is 1, it stays 1 until every done line has been sampled high at least once since the rise. The lines are bits 0..N_NODE-1 of `node_saved_i` and bits 0..N_DRAM-1 of `dram_flushed_i`, and they need not be high together. `ckpt_o` falls on the edge that samples the last missing line.
- R4: After `ckpt_o` falls, it stays 0 for at least two cycles. `busy_o` is 1 in the first of those cycles and 0 in the second. `busy_o` is 1 whenever `ckpt_o` is 1.
- R5: `epoch_o` increases by one, modulo 2^SEQ_W, on exactly the edge where `ckpt_o` falls, and holds its value on every other edge.
- R6: A high `ckpt_req_i` sampled while `busy_o` is 1 is held pending. `ckpt_o` then rises on the edge that ends the idle cycle after the commit. Any number of requests made during one checkpoint start exactly one further checkpoint.
- R7: Done answers seen during an earlier checkpoint do not count toward the current one. The sticky record is cleared when `ckpt_o` rises.
- R8: With `wdog_en_i` = 1 and `wdog_limit_i` = L, `wdog_err_o` goes to 1 after the edge that ends the (L+1)-th cycle of `ckpt_o` = 1, if the answers are not yet complete by then. The flag stays 1 until the next checkpoint starts, and `ckpt_o` keeps waiting for the answers.
- R9: With `wdog_en_i` = 0, `wdog_err_o` never rises, however long the answers take.
- R10: Done lines that are high while `busy_o` is 0 have no effect: `ckpt_o` stays 0 and `epoch_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ckpt_req_i | input | 1 | Checkpoint request (periodic tick or external) |
| node_saved_i | input | N_NODE | Per-node state-saved answers |
| dram_flushed_i | input | N_DRAM | Per-memory-log buffer-flushed answers |
| wdog_en_i | input | 1 | Enables the completion watchdog |
| wdog_limit_i | input | TMO_W | Watchdog limit L in cycles |
| ckpt_o | output | 1 | Broadcast checkpoint line; its falling edge is the commit |
| busy_o | output | 1 | A checkpoint or its commit cycle is in progress |
| epoch_o | output | SEQ_W | Count of committed checkpoints |
| wdog_err_o | output | 1 | Watchdog expired during the current or last checkpoint |

## Verification
The assertions assume that `rst_n` is held low across at least one rising edge and that every input is stable around that edge. They also assume that the watchdog enable and limit do not change while `ckpt_o` is high. The bench meets these assumptions by driving every input on the falling clock edge. It changes `wdog_en_i` and `wdog_limit_i` only while the coordinator is idle, and it holds reset for two full cycles. Done lines are raised only while `ckpt_o` is high, except in the vectors that check on purpose that idle answers are ignored.

// File: rtl/ckco_pkg.sv
package ckco_pkg;
  typedef enum logic [1:0] {
    CK_IDLE   = 2'd0,
    CK_SAVE   = 2'd1,
    CK_COMMIT = 2'd2
  } ck_state_e;
endpackage

// File: rtl/ckco_gather.sv
// Sticky record of participant answers, one flop per participant.
module ckco_gather #(
  parameter int N_NODE = 4,
  parameter int N_DRAM = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              arm_i,
  input  logic [N_NODE-1:0] node_saved_i,
  input  logic [N_DRAM-1:0] dram_flushed_i,
  output logic              all_now_o
);
  localparam int N_ALL = N_NODE + N_DRAM;

  logic [N_ALL-1:0] done_w;
  logic [N_ALL-1:0] seen_q;
  logic [N_ALL-1:0] hit_w;

  assign done_w = {dram_flushed_i, node_saved_i};

  for (genvar g = 0; g < N_ALL; g++) begin : g_part
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  seen_q[g] <= 1'b0;
      else if (clr_i)              seen_q[g] <= 1'b0;
      else if (arm_i && done_w[g]) seen_q[g] <= 1'b1;
    end
    assign hit_w[g] = seen_q[g] | done_w[g];
  end

  // complete when every participant is either recorded or answering now
  assign all_now_o = arm_i & (&hit_w);
endmodule

// File: rtl/ckco_timer.sv
// Completion watchdog: counts cycles of the save phase up to a limit.
module ckco_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             arm_i,
  input  logic             en_i,
  input  logic [TMO_W-1:0] limit_i,
  input  logic             all_now_i,
  output logic             err_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             reached_w;
  logic             expire_w;

  function automatic logic at_limit(input logic [TMO_W-1:0] c,
                                    input logic [TMO_W-1:0] l);
    return c == l;
  endfunction

  function automatic logic [TMO_W-1:0] bump(input logic [TMO_W-1:0] c);
    return c + TMO_W'(1);
  endfunction

  assign reached_w = at_limit(cnt_q, limit_i);
  assign expire_w  = arm_i & en_i & ~all_now_i & reached_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (start_i)            cnt_q <= '0;
    else if (arm_i && !reached_w) cnt_q <= bump(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_o <= 1'b0;
    else if (start_i)  err_o <= 1'b0;
    else if (expire_w) err_o <= 1'b1;
  end
endmodule

// File: rtl/ckco_ctrl.sv
// Phase sequencer, pending request and commit counter.
module ckco_ctrl
  import ckco_pkg::*;
#(
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             all_now_i,
  output ck_state_e        state_o,
  output logic             start_o,
  output logic             commit_o,
  output logic             pend_o,
  output logic [SEQ_W-1:0] seq_o
);
  ck_state_e st_q, st_d;
  logic      pend_q;
  logic      want_w;

  function automatic logic [SEQ_W-1:0] seq_next(input logic [SEQ_W-1:0] v);
    return v + SEQ_W'(1);
  endfunction

  assign want_w   = req_i | pend_q;
  assign start_o  = (st_q == CK_IDLE) && want_w;
  assign commit_o = (st_q == CK_SAVE) && all_now_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      CK_IDLE:   if (want_w)    st_d = CK_SAVE;
      CK_SAVE:   if (all_now_i) st_d = CK_COMMIT;
      CK_COMMIT:                st_d = CK_IDLE;
      default:                  st_d = CK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CK_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pend_q <= 1'b0;
    else if (start_o)                   pend_q <= 1'b0;
    else if (req_i && st_q != CK_IDLE)  pend_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seq_o <= '0;
    else if (commit_o) seq_o <= seq_next(seq_o);
  end

  assign state_o = st_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/ckpt_coordinator.sv
module ckpt_coordinator
  import ckco_pkg::*;
#(
  parameter int N_NODE = 4,
  parameter int N_DRAM = 2,
  parameter int SEQ_W  = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ckpt_req_i,
  input  logic [N_NODE-1:0] node_saved_i,
  input  logic [N_DRAM-1:0] dram_flushed_i,
  input  logic              wdog_en_i,
  input  logic [TMO_W-1:0]  wdog_limit_i,
  output logic              ckpt_o,
  output logic              busy_o,
  output logic [SEQ_W-1:0]  epoch_o,
  output logic              wdog_err_o
);
  // named internal events, also observed by the bound checker
  ck_state_e state;
  logic      start_evt;
  logic      commit_evt;
  logic      pend_w;
  logic      all_now;
  logic      in_save;

  assign in_save = (state == CK_SAVE);

  ckco_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (ckpt_req_i),
    .all_now_i (all_now),
    .state_o   (state),
    .start_o   (start_evt),
    .commit_o  (commit_evt),
    .pend_o    (pend_w),
    .seq_o     (epoch_o)
  );

  ckco_gather #(.N_NODE(N_NODE), .N_DRAM(N_DRAM)) u_gather (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr_i          (start_evt),
    .arm_i          (in_save),
    .node_saved_i   (node_saved_i),
    .dram_flushed_i (dram_flushed_i),
    .all_now_o      (all_now)
  );

  ckco_timer #(.TMO_W(TMO_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_evt),
    .arm_i     (in_save),
    .en_i      (wdog_en_i),
    .limit_i   (wdog_limit_i),
    .all_now_i (all_now),
    .err_o     (wdog_err_o)
  );

  assign ckpt_o = in_save;
  assign busy_o = (state != CK_IDLE);
endmodule

// File: rtl/ckco_checker.sv
module ckco_checker #(
  parameter int SEQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ckpt_req_i,
  input logic             wdog_en_i,
  input logic             ckpt_o,
  input logic             busy_o,
  input logic [SEQ_W-1:0] epoch_o,
  input logic             wdog_err_o,
  input logic             all_now,
  input logic             start_evt,
  input logic             pend_w
);
  AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ckpt_req_i) && !$past(busy_o)) |-> ckpt_o); // R2
  AST_RISE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ckpt_o) |-> !$past(busy_o)); // R2
  AST_FALL_ALL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ckpt_o) |-> $past(all_now)); // R3
  AST_COMMIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ckpt_o) |=> (!ckpt_o && !busy_o)); // R4
  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_o |-> busy_o); // R4
  AST_EPOCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ckpt_o) |-> (epoch_o == SEQ_W'($past(epoch_o) + SEQ_W'(1)))); // R5
  AST_EPOCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ckpt_o) |-> $stable(epoch_o)); // R5
  AST_PEND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_w && !busy_o) |=> ckpt_o); // R6
  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_err_o && !start_evt) |=> wdog_err_o); // R8
  AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_err_o) |-> $past(wdog_en_i)); // R9
endmodule

bind ckpt_coordinator ckco_checker #(.SEQ_W(SEQ_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ckpt_req_i (ckpt_req_i),
  .wdog_en_i  (wdog_en_i),
  .ckpt_o     (ckpt_o),
  .busy_o     (busy_o),
  .epoch_o    (epoch_o),
  .wdog_err_o (wdog_err_o),
  .all_now    (all_now),
  .start_evt  (start_evt),
  .pend_w     (pend_w)
);

// File: tb/tb_ckpt_coordinator.sv
`timescale 1ns/1ps
module tb_ckpt_coordinator;
  localparam int N_NODE = 4;
  localparam int N_DRAM = 2;
  localparam int SEQ_W  = 8;
  localparam int TMO_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic [N_NODE-1:0] node_d = '0;
  logic [N_DRAM-1:0] dram_d = '0;
  logic              wd_en = 1'b0;
  logic [TMO_W-1:0]  wd_lim = '0;
  logic              ckpt, busy, werr;
  logic [SEQ_W-1:0]  epoch;

  int checks = 0;
  int fails  = 0;
  logic [SEQ_W-1:0] exp_seq = '0;

  always #10 clk = ~clk; // 50 MHz

  ckpt_coordinator #(.N_NODE(N_NODE), .N_DRAM(N_DRAM), .SEQ_W(SEQ_W), .TMO_W(TMO_W)) dut (
    .clk(clk), .rst_n(rst_n), .ckpt_req_i(req), .node_saved_i(node_d),
    .dram_flushed_i(dram_d), .wdog_en_i(wd_en), .wdog_limit_i(wd_lim),
    .ckpt_o(ckpt), .busy_o(busy), .epoch_o(epoch), .wdog_err_o(werr));

  // row: request, answers {dram[1:0], node[3:0]}, expected ckpt, busy, epoch after the edge
  typedef struct packed {
    logic       rq;
    logic [5:0] dn;
    logic       ck;
    logic       bz;
    logic [7:0] sq;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'h00, 1'b0, 1'b0, 8'd0},  // idle
    '{1'b0, 6'h3F, 1'b0, 1'b0, 8'd0},  // R10 idle answers ignored
    '{1'b1, 6'h00, 1'b1, 1'b1, 8'd0},  // R2 start
    '{1'b0, 6'h01, 1'b1, 1'b1, 8'd0},  // R3 partial
    '{1'b0, 6'h02, 1'b1, 1'b1, 8'd0},
    '{1'b0, 6'h0C, 1'b1, 1'b1, 8'd0},
    '{1'b0, 6'h10, 1'b1, 1'b1, 8'd0},
    '{1'b0, 6'h20, 1'b0, 1'b1, 8'd1},  // R3 last answer commits, R5
    '{1'b0, 6'h00, 1'b0, 1'b0, 8'd1},  // R4 idle cycle
    '{1'b1, 6'h00, 1'b1, 1'b1, 8'd1},
    '{1'b0, 6'h3F, 1'b0, 1'b1, 8'd2},
    '{1'b1, 6'h00, 1'b0, 1'b0, 8'd2},  // R6 request during commit
    '{1'b0, 6'h00, 1'b1, 1'b1, 8'd2},  // R6 pending served
    '{1'b1, 6'h3F, 1'b0, 1'b1, 8'd3},  // R6 request on commit edge
    '{1'b0, 6'h00, 1'b0, 1'b0, 8'd3},
    '{1'b0, 6'h00, 1'b1, 1'b1, 8'd3},
    '{1'b0, 6'h15, 1'b1, 1'b1, 8'd3},
    '{1'b0, 6'h2A, 1'b0, 1'b1, 8'd4},
    '{1'b0, 6'h00, 1'b0, 1'b0, 8'd4},
    '{1'b0, 6'h00, 1'b0, 1'b0, 8'd4},  // R6 no extra checkpoint
    '{1'b1, 6'h00, 1'b1, 1'b1, 8'd4},
    '{1'b1, 6'h3E, 1'b1, 1'b1, 8'd4},  // R7 old bit0 not counted; request pends
    '{1'b0, 6'h01, 1'b0, 1'b1, 8'd5},
    '{1'b0, 6'h00, 1'b0, 1'b0, 8'd5},
    '{1'b0, 6'h00, 1'b1, 1'b1, 8'd5},
    '{1'b0, 6'h3F, 1'b0, 1'b1, 8'd6},
    '{1'b0, 6'h00, 1'b0, 1'b0, 8'd6}
  };

  task automatic chk(input string req_tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  // apply inputs for one cycle, return at the next falling edge
  task automatic cyc(input logic rq, input logic [5:0] dn);
    req    = rq;
    node_d = dn[3:0];
    dram_d = dn[5:4];
    @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1", "ckpt in reset", 32'(ckpt), 0);
    chk("R1", "busy in reset", 32'(busy), 0);
    chk("R1", "epoch in reset", 32'(epoch), 0);
    chk("R1", "err in reset", 32'(werr), 0);
    rst_n = 1'b1;

    // table walk (R2 R3 R4 R5 R6 R7 R10)
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].rq, VEC[i].dn);
      chk("R2/R3/R4/R6/R7/R10", $sformatf("row %0d ckpt", i), 32'(ckpt), 32'(VEC[i].ck));
      chk("R4", $sformatf("row %0d busy", i), 32'(busy), 32'(VEC[i].bz));
      chk("R5", $sformatf("row %0d epoch", i), 32'(epoch), 32'(VEC[i].sq));
      chk("R9", $sformatf("row %0d err", i), 32'(werr), 0);
    end
    exp_seq = 8'd6;

    // R5 wrap of the counter
    for (int k = 0; k < 250; k++) begin
      cyc(1'b1, 6'h00);
      cyc(1'b0, 6'h3F);
      exp_seq = exp_seq + 8'd1;
      cyc(1'b0, 6'h00);
    end
    chk("R5", "epoch wrapped", 32'(epoch), 32'(exp_seq));
    chk("R5", "epoch wrap value", 32'(epoch), 0);

    // R8 watchdog with limit 3
    wd_en  = 1'b1;
    wd_lim = 16'd3;
    cyc(1'b1, 6'h00);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 6'h00);
      chk("R8", $sformatf("err before limit %0d", k), 32'(werr), 0);
    end
    cyc(1'b0, 6'h00);
    chk("R8", "err at limit", 32'(werr), 1);
    chk("R8", "still waiting", 32'(ckpt), 1);
    cyc(1'b0, 6'h1F);
    chk("R8", "err held", 32'(werr), 1);
    chk("R8", "still waiting after partial", 32'(ckpt), 1);
    cyc(1'b0, 6'h20);
    exp_seq = exp_seq + 8'd1;
    chk("R8", "commit after timeout", 32'(ckpt), 0);
    chk("R8", "err kept past commit", 32'(werr), 1);
    cyc(1'b0, 6'h00);
    cyc(1'b1, 6'h00);
    chk("R8", "err cleared on start", 32'(werr), 0);
    cyc(1'b0, 6'h3F);
    exp_seq = exp_seq + 8'd1;
    chk("R8", "fast answer no error", 32'(werr), 0);
    cyc(1'b0, 6'h00);

    // R9 watchdog disabled
    wd_en  = 1'b0;
    wd_lim = 16'd0;
    cyc(1'b1, 6'h00);
    for (int k = 0; k < 8; k++) cyc(1'b0, 6'h00);
    chk("R9", "no err when disabled", 32'(werr), 0);
    chk("R9", "still waiting", 32'(ckpt), 1);
    cyc(1'b0, 6'h3F);
    exp_seq = exp_seq + 8'd1;
    chk("R5", "epoch after disabled run", 32'(epoch), 32'(exp_seq));
    cyc(1'b0, 6'h00);

    // R1 reset during a checkpoint
    cyc(1'b1, 6'h00);
    chk("R2", "started before reset", 32'(ckpt), 1);
    rst_n = 1'b0;
    req   = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "ckpt after mid reset", 32'(ckpt), 0);
    chk("R1", "busy after mid reset", 32'(busy), 0);
    chk("R1", "epoch after mid reset", 32'(epoch), 0);
    rst_n = 1'b1;
    cyc(1'b0, 6'h3F);
    chk("R10", "answers after reset ignored", 32'(ckpt), 0);
    chk("R10", "epoch after idle answers", 32'(epoch), 0);

    summary();
    $finish;
  end
endmodule